// File: doc/BRIEF.md
# Time-Domain Integration Gray-Level Mirror Shifter

This block drives a strictly binary mirror array so that each spot on a moving substrate gets a dose that matches a 5-bit gray level. A spot enters the array at one edge and moves one mirror column per line clock. For every pixel row, the block takes one gray value per line clock. It splits the value into its bits and sends each bit through a chain of registers, so that the bit switches the mirrors of that bit's own column group while the spot passes over that group. A group for bit k is `SUB * 2^k` columns wide. A spot that crosses the whole array of `SUB * 31` columns is therefore lit for exactly `gray * SUB` line periods.

Every column group except the one for bit 0 is split into two equal halves. The halves sit mirror-symmetrically about the array centre. Each bit has its own input delay that brings it to its first half. A bridge delay then carries the bit across the columns that lie between its two halves. Each column is one registered stage, so the array advances at the full line rate.

Top module: `tdi_mirror_shifter`

## Requirements
- R1: In the cycle after any clock edge with `rst` high, every bit of `mirror_o` is 0. After reset, a column stays OFF until a pixel accepted after reset has reached it.
- R2: Column c is column 0 at the entry edge. Going from the entry edge, the columns belong to these groups, in this order: bit 4 first half (8·SUB), bit 3 first half (4·SUB), bit 2 first half (2·SUB), bit 1 first half (SUB), bit 0 (SUB), bit 1 second half (SUB), bit 2 second half (2·SUB), bit 3 second half (4·SUB), bit 4 second half (8·SUB).
- R3: The pattern advances by exactly one column per line clock. Within a group, column c after edge E+1 equals column c−1 after edge E.
- R4: Take a pixel for row r that is presented at rising edge E. After edge E+c, mirror bit `mirror_o[c*ROWS + r]` equals bit b of that pixel, where b is the group that owns column c (R2). The gray bit b of row r is `gray_i[r*GRAY_W + b]`.
- R5: For any input stream, the ON count seen by a spot over its full 31·SUB-column traversal equals `gray * SUB` for its row.
- R6: An edge with `line_valid_i` low enters an all-zero pixel for every row, whatever `gray_i` holds.
- R7: Rows are independent. The mirrors of one row depend only on that row's gray values.
- R8: A pixel with gray value 0 turns no mirror ON during its traversal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; one line per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_valid_i | input | 1 | High when `gray_i` carries a line of pixels |
| gray_i | input | ROWS*GRAY_W | Gray value per row; row r at bits `r*GRAY_W +: GRAY_W` |
| mirror_o | output | SUB*(2^GRAY_W-1)*ROWS | Mirror ON/OFF state; column c, row r at bit `c*ROWS + r` |

## Verification
A pixel presented at rising edge E shows in column c right after edge E+c, because every column is a single register. The entry column therefore changes after the very edge that accepts the pixel. Inputs are driven at the falling edge. The outputs are sampled at the next falling edge, so the sample after edge T is compared with a model vector in which column c holds the pixel accepted at edge T−c. Each spot's exposure is added up from those same samples. The total is checked only after 31·SUB further invalid lines have carried the last real pixel out of the array.

// File: rtl/tdi_pkg.sv
package tdi_pkg;

    // Width of one half of the group for bit k (k >= 1).
    function automatic int half_width(input int k, input int sub);
        return sub * (1 << (k - 1));
    endfunction

    // First column of the entry-side half of bit k (k >= 1).
    function automatic int start_first(input int k, input int sub, input int gw);
        return sub * ((1 << (gw - 1)) - (1 << k));
    endfunction

    // First column of the exit-side half of bit k (k >= 1).
    function automatic int start_second(input int k, input int sub, input int gw);
        return sub * ((1 << (gw - 1)) + (1 << (k - 1)) - 1);
    endfunction

    // First column of the bit-0 group at the array centre.
    function automatic int centre_start(input int sub, input int gw);
        return sub * ((1 << (gw - 1)) - 1);
    endfunction

    function automatic int total_cols(input int sub, input int gw);
        return sub * ((1 << gw) - 1);
    endfunction

    // Gray bit that owns a column.
    function automatic int bit_of_col(input int c, input int sub, input int gw);
        for (int k = 1; k < gw; k++) begin
            if ((c >= start_first(k, sub, gw)) &&
                (c < start_first(k, sub, gw) + half_width(k, sub)))
                return k;
            if ((c >= start_second(k, sub, gw)) &&
                (c < start_second(k, sub, gw) + half_width(k, sub)))
                return k;
        end
        return 0;
    endfunction

endpackage

// File: rtl/tdi_delay_line.sv
module tdi_delay_line #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/tdi_block_chain.sv
module tdi_block_chain #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIDTH-1:0]       d_i,
    output logic [DEPTH*WIDTH-1:0] taps_o
);
    logic [WIDTH-1:0] col_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) col_q[i] <= '0;
        end else begin
            col_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) col_q[i] <= col_q[i-1];
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) taps_o[i*WIDTH +: WIDTH] = col_q[i];
    end
endmodule

// File: rtl/tdi_mirror_shifter.sv
module tdi_mirror_shifter
    import tdi_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int SUB    = 8,
    parameter int GRAY_W = 5
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         line_valid_i,
    input  logic [ROWS*GRAY_W-1:0]                       gray_i,
    output logic [tdi_pkg::total_cols(SUB, GRAY_W)*ROWS-1:0] mirror_o
);
    localparam int COLS = total_cols(SUB, GRAY_W);
    localparam int CTR  = centre_start(SUB, GRAY_W);

    // Bit planes: one ROWS-wide vector per gray bit, zeroed on invalid lines.
    logic [ROWS-1:0] plane [GRAY_W];
    logic [ROWS-1:0] col_st [COLS];

    always_comb begin
        for (int k = 0; k < GRAY_W; k++)
            for (int r = 0; r < ROWS; r++)
                plane[k][r] = line_valid_i & gray_i[r*GRAY_W + k];
    end

    for (genvar k = 0; k < GRAY_W; k++) begin : g_bit
        if (k == 0) begin : g_centre
            logic [ROWS-1:0]     head;
            logic [SUB*ROWS-1:0] taps;
            tdi_delay_line #(.DEPTH(CTR), .WIDTH(ROWS)) u_in_dly (
                .clk(clk), .rst(rst), .d_i(plane[0]), .q_o(head));
            tdi_block_chain #(.DEPTH(SUB), .WIDTH(ROWS)) u_blk (
                .clk(clk), .rst(rst), .d_i(head), .taps_o(taps));
            for (genvar j = 0; j < SUB; j++) begin : g_col
                assign col_st[CTR + j] = taps[j*ROWS +: ROWS];
            end
        end else begin : g_pair
            localparam int SA  = start_first(k, SUB, GRAY_W);
            localparam int SB  = start_second(k, SUB, GRAY_W);
            localparam int HW  = half_width(k, SUB);
            localparam int GAP = SB - (SA + HW);
            logic [ROWS-1:0]    head;
            logic [ROWS-1:0]    bridged;
            logic [HW*ROWS-1:0] taps_a;
            logic [HW*ROWS-1:0] taps_b;

            if (SA == 0) begin : g_no_dly
                assign head = plane[k];
            end else begin : g_dly
                tdi_delay_line #(.DEPTH(SA), .WIDTH(ROWS)) u_in_dly (
                    .clk(clk), .rst(rst), .d_i(plane[k]), .q_o(head));
            end

            tdi_block_chain #(.DEPTH(HW), .WIDTH(ROWS)) u_half_a (
                .clk(clk), .rst(rst), .d_i(head), .taps_o(taps_a));
            tdi_delay_line #(.DEPTH(GAP), .WIDTH(ROWS)) u_bridge (
                .clk(clk), .rst(rst),
                .d_i(taps_a[(HW-1)*ROWS +: ROWS]), .q_o(bridged));
            tdi_block_chain #(.DEPTH(HW), .WIDTH(ROWS)) u_half_b (
                .clk(clk), .rst(rst), .d_i(bridged), .taps_o(taps_b));

            for (genvar j = 0; j < HW; j++) begin : g_col
                assign col_st[SA + j] = taps_a[j*ROWS +: ROWS];
                assign col_st[SB + j] = taps_b[j*ROWS +: ROWS];
            end
        end
    end

    always_comb begin
        for (int c = 0; c < COLS; c++) mirror_o[c*ROWS +: ROWS] = col_st[c];
    end
endmodule

// File: rtl/tdi_mirror_shifter_chk.sv
module tdi_mirror_shifter_chk
    import tdi_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int SUB    = 8,
    parameter int GRAY_W = 5
) (
    input logic                                         clk,
    input logic                                         rst,
    input logic                                         line_valid_i,
    input logic [ROWS*GRAY_W-1:0]                       gray_i,
    input logic [tdi_pkg::total_cols(SUB, GRAY_W)*ROWS-1:0] mirror_o
);
    localparam int COLS = total_cols(SUB, GRAY_W);

    logic [ROWS-1:0] top_bit;
    always_comb begin
        for (int r = 0; r < ROWS; r++) top_bit[r] = gray_i[r*GRAY_W + GRAY_W - 1];
    end

    // R1: a reset edge leaves every mirror OFF.
    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (mirror_o == '0));

    // R4: entry column shows the top gray bit accepted at the previous edge.
    p_entry_col_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mirror_o[ROWS-1:0] == $past(top_bit & {ROWS{line_valid_i}})));

    // R6: an invalid line enters nothing.
    p_invalid_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(line_valid_i)) |-> (mirror_o[ROWS-1:0] == '0));

    // R8: a zero gray value never lights the entry column of its row.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        p_zero_gray_r8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && ($past(gray_i[r*GRAY_W +: GRAY_W]) == '0)) |->
            !mirror_o[r]);
    end

    // R3: within a group the pattern moves one column per line clock.
    for (genvar c = 1; c < COLS; c++) begin : g_col
        if (bit_of_col(c, SUB, GRAY_W) == bit_of_col(c - 1, SUB, GRAY_W)) begin : g_same
            p_shift_r3: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |->
                (mirror_o[c*ROWS +: ROWS] == $past(mirror_o[(c-1)*ROWS +: ROWS])));
        end
    end
endmodule

bind tdi_mirror_shifter tdi_mirror_shifter_chk #(
    .ROWS(ROWS), .SUB(SUB), .GRAY_W(GRAY_W)
) u_chk (
    .clk(clk), .rst(rst), .line_valid_i(line_valid_i),
    .gray_i(gray_i), .mirror_o(mirror_o)
);

// File: tb/tdi_mirror_shifter_bench.sv
module tdi_mirror_shifter_bench;
    localparam int ROWS = 4;
    localparam int SUB  = 8;
    localparam int GW   = 5;
    localparam int COLS = SUB * ((1 << GW) - 1);
    localparam int MAXH = 2048;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 line_valid = 1'b0;
    logic [ROWS*GW-1:0]   gray = '0;
    logic [COLS*ROWS-1:0] mirror;

    tdi_mirror_shifter #(.ROWS(ROWS), .SUB(SUB), .GRAY_W(GW)) u_tdi_mirror_shifter (
        .clk(clk), .rst(rst), .line_valid_i(line_valid),
        .gray_i(gray), .mirror_o(mirror));

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int t = 0;
    int hist [MAXH][ROWS];
    int acc  [MAXH][ROWS];
    int colbit [COLS];
    bit done = 1'b0;

    // Group ownership per column, built from the R2 layout.
    task automatic build_layout();
        int pos = 0;
        for (int k = GW - 1; k >= 1; k--)
            for (int j = 0; j < SUB * (1 << (k - 1)); j++) begin colbit[pos] = k; pos++; end
        for (int j = 0; j < SUB; j++) begin colbit[pos] = 0; pos++; end
        for (int k = 1; k < GW; k++)
            for (int j = 0; j < SUB * (1 << (k - 1)); j++) begin colbit[pos] = k; pos++; end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; line_valid = 1'b0; gray = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t = 0;
        for (int i = 0; i < MAXH; i++)
            for (int r = 0; r < ROWS; r++) begin hist[i][r] = 0; acc[i][r] = 0; end
        check(mirror == '0, "R1", "mirror after reset (ON count)", $countones(mirror), 0);
    endtask

    // Drive one line, then compare the whole vector after the accepting edge.
    task automatic step(input bit v, input logic [ROWS*GW-1:0] g, input string tag);
        int bad_c = -1, bad_r = 0, bad_a = 0, bad_e = 0;
        line_valid = v; gray = g;
        @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < ROWS; r++) hist[t][r] = v ? int'(g[r*GW +: GW]) : 0;
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++) begin
                int idx = t - c;
                int e = (idx >= 0) ? ((hist[idx][r] >> colbit[c]) & 1) : 0;
                int a = int'(mirror[c*ROWS + r]);
                if (idx >= 0) acc[idx][r] += a;
                if (a != e && bad_c < 0) begin bad_c = c; bad_r = r; bad_a = a; bad_e = e; end
            end
        check(bad_c < 0, tag, $sformatf("line %0d col %0d row %0d", t, bad_c, bad_r), bad_a, bad_e);
        if (t < MAXH - 1) t++;
    endtask

    task automatic flush();
        repeat (COLS) step(1'b0, '1, "R3");
    endtask

    task automatic check_exposure(input int n_pix, input string tag);
        for (int i = 0; i < n_pix; i++)
            for (int r = 0; r < ROWS; r++)
                check(acc[i][r] == hist[i][r] * SUB,
                      (hist[i][r] == 0 && tag == "R5") ? "R8" : tag,
                      $sformatf("exposure pixel %0d row %0d", i, r),
                      acc[i][r], hist[i][r] * SUB);
    endtask

    // R1: reset state and fill with full-scale pixels.
    task automatic t_reset_fill();
        do_reset();
        step(1'b1, '1, "R1");
        check($countones(mirror) == ROWS, "R1", "ON count after first line",
              $countones(mirror), ROWS);
        repeat (29) step(1'b1, '1, "R1");
        flush();
        check_exposure(30, "R5");
    endtask

    // R2: a single set bit lights exactly its own group.
    task automatic t_single_bits();
        for (int k = 0; k < GW; k++) begin
            logic [ROWS*GW-1:0] g;
            do_reset();
            for (int r = 0; r < ROWS; r++) g[r*GW +: GW] = GW'(1 << k);
            step(1'b1, g, "R2");
            repeat (COLS) step(1'b0, '0, "R2");
            check_exposure(1, "R2");
        end
    endtask

    // R4/R5/R8: random stream with 0 and 31 back to back.
    task automatic t_random();
        do_reset();
        for (int i = 0; i < 200; i++) begin
            logic [ROWS*GW-1:0] g;
            for (int r = 0; r < ROWS; r++) begin
                if (i % 10 == 3)      g[r*GW +: GW] = '0;
                else if (i % 10 == 4) g[r*GW +: GW] = '1;
                else                  g[r*GW +: GW] = GW'($urandom_range(0, 31));
            end
            step(1'b1, g, "R4");
        end
        flush();
        check_exposure(200, "R5");
    endtask

    // R6: invalid lines with nonzero data enter zero pixels.
    task automatic t_valid_gaps();
        do_reset();
        for (int i = 0; i < 60; i++) step(((i % 3) == 0), '1, "R6");
        flush();
        check_exposure(60, "R6");
    endtask

    // R7: distinct values per row, one row held at zero.
    task automatic t_rows();
        do_reset();
        for (int i = 0; i < 40; i++) begin
            logic [ROWS*GW-1:0] g;
            for (int r = 0; r < ROWS; r++)
                g[r*GW +: GW] = (r == 0) ? '0 : GW'((i * 7 + r * 11) % 32);
            step(1'b1, g, "R7");
        end
        flush();
        check_exposure(40, "R7");
    endtask

    initial begin
        build_layout();
        t_reset_fill();
        t_single_bits();
        t_random();
        t_valid_gaps();
        t_rows();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule